// File: doc/BRIEF.md
# Pin-Selected Integer-N Phase Detector Core

This block is the digital heart of an integer-N clock multiplier loop. It takes a reference clock and a feedback clock from an external oscillator and divides the feedback by 1, 5 or 10. It compares the rising edges of the divided feedback against the reference and emits pump-up and pump-down pulses for an external charge pump. A lock monitor times how far apart the two edges land and raises a single lock flag once the loop has settled.

Everything runs on a fast sampling clock `clk`. The two clock inputs are treated as sampled data, and every timing window is counted in `clk` cycles. A two-bit strap code picks the divide ratio or puts the core into a power-down state. In power-down the pump drive enable is withdrawn and the clock inputs are ignored. The loop filter, charge pump and oscillator live outside this block.

Top module: `pll_pfd_core`

## Requirements
- R1: The strap code `sel_i` (bit 0 and bit 1) decodes as follows: 2'b00 is power-down, 2'b01 is divide by 1, 2'b10 is divide by 5 and 2'b11 is divide by 10.
- R2: In divide-by-1 mode, every rising edge of `fb_i` counts as a feedback edge at the phase detector.
- R3: In divide-by-5 mode, after a clean start, the fifth rising edge of `fb_i` is the first feedback edge. Edges one to four give no `dn_o`.
- R4: In divide-by-10 mode, after a clean start, the tenth rising edge of `fb_i` is the first feedback edge.
- R5: A reference edge sampled at clock edge k drives `up_o` high from edge k. It stays high until the clear. A feedback edge sets `dn_o` the same way. The later of the two edges sets the second output.
- R6: When `up_o` and `dn_o` are both high, both go low at the next clock edge. Edges that coincide give a one-cycle pulse on both outputs.
- R7: One clock after code 2'b00 is sampled, `up_o`, `dn_o`, `lock_o` and `cp_oe_o` are low. Edges on `ref_i` and `fb_i` have no effect while the code stays 2'b00. Any other code sets `cp_oe_o` one clock later.
- R8: The edge offset is counted in `clk` cycles. An offset of exactly `WIN_CYC` cycles still counts as in window.
- R9: `lock_o` rises one clock after both pulses are high on the `LOCK_CNT`-th in-window comparison in a row. It stays low before that.
- R10: `lock_o` drops as soon as one pulse has been high alone for more than `WIN_CYC` cycles. With a leading edge at clock edge k, `lock_o` is low from edge k+`WIN_CYC`+1.
- R11: At the clock edge where `sel_i` first differs from its previous value, the divider count, both pulses, the offset count and `lock_o` are cleared.
- R12: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 2 | Strap code: ratio select or power-down |
| ref_i | input | 1 | Reference clock, sampled |
| fb_i | input | 1 | Oscillator feedback clock, sampled |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| cp_oe_o | output | 1 | Pump drive enable, low in power-down |
| lock_o | output | 1 | Lock flag |

## Verification
A divider count that is off by one shows up at the first feedback comparison after a ratio change: `dn_o` rises on the wrong `fb_i` pulse, one sample early or late. A pulse register that is not cleared keeps both outputs high past the one-cycle reset delay, and the bench catches this in the cycle after the overlap. A faulty offset counter moves the lock transitions. The bench checks the exact cycle in which `lock_o` rises at the in-window boundary and the exact cycle in which it falls on a late edge.

// File: rtl/pllpd_pkg.sv
package pllpd_pkg;

   typedef enum logic [1:0] {
      SEL_OFF   = 2'b00,
      SEL_DIV1  = 2'b01,
      SEL_DIV5  = 2'b10,
      SEL_DIV10 = 2'b11
   } sel_e;

   localparam int DIV_CW = 4;

   // terminal count of the feedback divider for a given strap code
   function automatic logic [DIV_CW-1:0] last_count(input sel_e s);
      case (s)
         SEL_DIV5:  last_count = DIV_CW'(4);
         SEL_DIV10: last_count = DIV_CW'(9);
         default:   last_count = '0;
      endcase
   endfunction

endpackage

// File: rtl/pllpd_fbdiv.sv
module pllpd_fbdiv
   import pllpd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  sel_e sel,
   input  logic fb_rise,
   output logic fb_tick
);
   logic [DIV_CW-1:0] cnt_q;
   logic [DIV_CW-1:0] term;

   assign term    = last_count(sel);
   assign fb_tick = !clr && fb_rise && (cnt_q == term);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (fb_rise) begin
         cnt_q <= (cnt_q == term) ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pllpd_pfd.sv
module pllpd_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ref_rise,
   input  logic fb_tick,
   output logic up_q,
   output logic dn_q
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (up_q && dn_q) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= up_q | ref_rise;
         dn_q <= dn_q | fb_tick;
      end
   end
endmodule

// File: rtl/pllpd_lockmon.sv
module pllpd_lockmon #(
   parameter int WIN_CYC  = 3,
   parameter int LOCK_CNT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic up,
   input  logic dn,
   output logic lock_q
);
   localparam int OW = $clog2(WIN_CYC + 2);
   localparam logic [OW-1:0] WIN = OW'(WIN_CYC);

   logic [OW-1:0] off_q;
   logic one_sided, done, good, bad;

   assign one_sided = up ^ dn;
   assign done      = up & dn;
   assign good      = done && (off_q <= WIN);
   assign bad       = (one_sided && (off_q >= WIN)) || (done && (off_q > WIN));

   always_ff @(posedge clk) begin
      if (!rst_n || clr || done) begin
         off_q <= '0;
      end else if (one_sided && (off_q <= WIN)) begin
         off_q <= off_q + 1'b1;
      end
   end

   generate
      if (LOCK_CNT == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n || clr || bad) lock_q <= 1'b0;
            else if (good)            lock_q <= 1'b1;
         end
      end else begin : g_streak
         localparam int SW = $clog2(LOCK_CNT + 1);
         localparam logic [SW-1:0] LAST = SW'(LOCK_CNT - 1);
         logic [SW-1:0] streak_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr || bad) begin
               streak_q <= '0;
               lock_q   <= 1'b0;
            end else if (good) begin
               if (streak_q == LAST) lock_q <= 1'b1;
               else                  streak_q <= streak_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pll_pfd_core.sv
module pll_pfd_core
   import pllpd_pkg::*;
#(
   parameter int WIN_CYC  = 3,
   parameter int LOCK_CNT = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel_i,
   input  logic       ref_i,
   input  logic       fb_i,
   output logic       up_o,
   output logic       dn_o,
   output logic       cp_oe_o,
   output logic       lock_o
);
   generate
      if (WIN_CYC < 1) begin : g_bad_win
         $error("WIN_CYC must be at least 1");
      end
      if (LOCK_CNT < 1) begin : g_bad_lock
         $error("LOCK_CNT must be at least 1");
      end
   endgenerate

   sel_e sel, sel_q;
   logic ref_q, fb_q, ref_rise, fb_rise, fb_tick, clr;

   assign sel      = sel_e'(sel_i);
   assign ref_rise = ref_i & ~ref_q;
   assign fb_rise  = fb_i & ~fb_q;
   assign clr      = (sel != sel_q) || (sel == SEL_OFF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q   <= SEL_OFF;
         ref_q   <= 1'b0;
         fb_q    <= 1'b0;
         cp_oe_o <= 1'b0;
      end else begin
         sel_q   <= sel;
         ref_q   <= ref_i;
         fb_q    <= fb_i;
         cp_oe_o <= (sel != SEL_OFF);
      end
   end

   pllpd_fbdiv u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .sel     (sel),
      .fb_rise (fb_rise),
      .fb_tick (fb_tick)
   );

   pllpd_pfd u_pfd (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .ref_rise (ref_rise),
      .fb_tick  (fb_tick),
      .up_q     (up_o),
      .dn_q     (dn_o)
   );

   pllpd_lockmon #(.WIN_CYC(WIN_CYC), .LOCK_CNT(LOCK_CNT)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .up     (up_o),
      .dn     (dn_o),
      .lock_q (lock_o)
   );
endmodule

// File: rtl/pll_pfd_core_chk.sv
module pll_pfd_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] sel_i,
   input logic       up_o,
   input logic       dn_o,
   input logic       cp_oe_o,
   input logic       lock_o
);
   assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == 2'b00) |=> (!up_o && !dn_o && !lock_o && !cp_oe_o));

   assert_oe_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i != 2'b00) |=> cp_oe_o);

   assert_pulse_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_o && dn_o) |=> (!up_o && !dn_o));

   assert_lock_on_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> $past(up_o && dn_o));

   assert_mode_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i != $past(sel_i)) |=> (!lock_o && !up_o && !dn_o));
endmodule

bind pll_pfd_core pll_pfd_core_chk u_chk (.*);

// File: tb/test_pll_pfd_core.sv
`timescale 1ns/1ps
module test_pll_pfd_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel_i = 2'b01;
   logic       ref_i = 1'b0;
   logic       fb_i = 1'b0;
   logic       up_o, dn_o, cp_oe_o, lock_o;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   logic up_s[32], dn_s[32], lk_s[32], oe_s[32];

   always #4 clk = ~clk;

   pll_pfd_core #(.WIN_CYC(3), .LOCK_CNT(4)) i_pll_pfd_core (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .ref_i(ref_i), .fb_i(fb_i),
      .up_o(up_o), .dn_o(dn_o), .cp_oe_o(cp_oe_o), .lock_o(lock_o)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // one comparison window: ref pulse at step r, nf fb pulses from step f0 every 2 steps
   task automatic wave(input int len, input int r, input int f0, input int nf);
      for (int j = 0; j < len; j++) begin
         ref_i = (j == r);
         fb_i  = 1'b0;
         for (int k = 0; k < nf; k++) if (j == f0 + 2*k) fb_i = 1'b1;
         @(negedge clk);
         up_s[j] = up_o; dn_s[j] = dn_o; lk_s[j] = lock_o; oe_s[j] = cp_oe_o;
      end
      ref_i = 1'b0;
      fb_i  = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] m);
      sel_i = m;
      ref_i = 1'b0;
      fb_i  = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R12 up in reset", up_o, 1'b0);
      check("R12 dn in reset", dn_o, 1'b0);
      check("R12 lock in reset", lock_o, 1'b0);
      check("R12 oe in reset", cp_oe_o, 1'b0);
   endtask

   task automatic t_ref_leads();
      wave(8, 1, 3, 1);
      check("R5 up set after ref", up_s[1], 1'b1);
      check("R5 dn low before fb", dn_s[2], 1'b0);
      check("R2 dn on first fb edge", dn_s[3], 1'b1);
      check("R6 up cleared", up_s[4], 1'b0);
      check("R6 dn cleared", dn_s[4], 1'b0);
      check("R7 oe on in div1", oe_s[0], 1'b1);
   endtask

   task automatic t_fb_leads();
      wave(8, 3, 1, 1);
      check("R5 dn set when fb leads", dn_s[1], 1'b1);
      check("R5 up low before ref", up_s[2], 1'b0);
      check("R5 up on ref", up_s[3], 1'b1);
      check("R6 dn cleared", dn_s[4], 1'b0);
   endtask

   task automatic t_coincident();
      wave(6, 1, 1, 1);
      check("R6 coincident up", up_s[1], 1'b1);
      check("R6 coincident dn", dn_s[1], 1'b1);
      check("R6 coincident up cleared", up_s[2], 1'b0);
      check("R6 coincident dn cleared", dn_s[2], 1'b0);
   endtask

   task automatic t_lock_acquire();
      set_mode(2'b11);
      set_mode(2'b01);
      for (int w = 0; w < 3; w++) begin
         wave(6, 1, 2, 1);
         check("R9 no lock before count", lk_s[5], 1'b0);
      end
      wave(6, 1, 2, 1);
      check("R9 lock not early", lk_s[2], 1'b0);
      check("R9 lock after fourth", lk_s[3], 1'b1);
   endtask

   task automatic t_late_edge();
      wave(12, 1, 7, 1);
      check("R10 lock held at window", lk_s[4], 1'b1);
      check("R10 lock drops past window", lk_s[5], 1'b0);
      check("R10 dn on late edge", dn_s[7], 1'b1);
      check("R10 lock stays low", lk_s[9], 1'b0);
   endtask

   task automatic t_boundary();
      for (int w = 0; w < 3; w++) begin
         wave(8, 1, 4, 1);
         check("R8 boundary no lock yet", lk_s[7], 1'b0);
      end
      wave(8, 1, 4, 1);
      check("R8 boundary lock not early", lk_s[4], 1'b0);
      check("R8 offset equal to window locks", lk_s[5], 1'b1);
   endtask

   task automatic t_mode_change();
      set_mode(2'b10);
      check("R11 lock cleared on code change", lock_o, 1'b0);
      wave(8, -1, 1, 3);
      check("R3 no dn on third edge", dn_s[5], 1'b0);
      set_mode(2'b11);
      wave(24, 19, 1, 10);
      check("R11 count restarted, no dn at seventh", dn_s[13], 1'b0);
      check("R4 no dn at ninth", dn_s[17], 1'b0);
      check("R4 dn on tenth edge", dn_s[19], 1'b1);
      check("R4 up on aligned ref", up_s[19], 1'b1);
   endtask

   task automatic t_div5();
      set_mode(2'b10);
      wave(14, 9, 1, 5);
      check("R3 no dn on fourth edge", dn_s[7], 1'b0);
      check("R3 dn on fifth edge", dn_s[9], 1'b1);
      check("R1 code 2'b10 runs", oe_s[0], 1'b1);
      check("R6 cleared after div5 pair", dn_s[10], 1'b0);
   endtask

   task automatic t_power_down();
      set_mode(2'b00);
      check("R7 oe low in power-down", cp_oe_o, 1'b0);
      wave(10, 1, 3, 1);
      for (int j = 0; j < 10; j++) begin
         check("R7 up ignored", up_s[j], 1'b0);
         check("R7 dn ignored", dn_s[j], 1'b0);
      end
      check("R7 lock low", lk_s[9], 1'b0);
      set_mode(2'b01);
      check("R1 code 2'b01 enables drive", cp_oe_o, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      t_ref_leads();
      t_fb_leads();
      t_coincident();
      t_lock_acquire();
      t_late_edge();
      t_boundary();
      t_mode_change();
      t_div5();
      t_power_down();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule